// File: doc/BRIEF.md
# Banked Internal Data Memory Front End

This block is the 256-byte on-chip data memory of a small 8-bit controller, together with the logic that turns an access request into a physical location. One request port carries an access kind, an 8-bit address, a write flag, write data and a single bit value. The kind decides how the address is read: as a register number in the active bank, as a direct address, as an indirect pointer held in a working register, as a bit address, or as a stack push or pop. Locations the direct and bit spaces give to special-function registers go out on a separate SFR port. The SFR port is combinational and is answered in the same cycle.

The block holds the stack pointer. Single-bit writes are done as read-modify-write of the containing byte within one request cycle, for RAM and for SFRs. Read results appear on registered outputs with a valid pulse one cycle after the request. Kind codes 6 and 7 are reserved and do nothing.

Top module: `dmem_front`

## Requirements
- R1: After reset `sp_o` is 07h, `rvalid_o` is 0 and every RAM byte reads 00h.
- R2: Kind 0 (register) reaches physical byte `bank_i*8 + addr_i[2:0]`, so the four banks of eight registers occupy 00h–1Fh.
- R3: Kind 1 (direct) with address 00h–7Fh reaches that RAM byte. With address 80h–FFh it drives the SFR port at the same address and leaves RAM untouched.
- R4: Kind 2 (indirect) uses working register R0 (`addr_i[0]`=0) or R1 (`addr_i[0]`=1) of the active bank as a pointer, and reaches all 256 RAM bytes, including 80h–FFh.
- R5: Kind 3 (bit) with bit address 00h–7Fh selects bit `addr_i[2:0]` of RAM byte `20h + addr_i[6:3]`. A bit write changes only that bit. A bit read returns it on `bit_o`.
- R6: Kind 3 with bit address 80h–FFh targets SFR `{addr_i[7:3],000}` with `sfr_bit_o`=1. A bit read returns bit `addr_i[2:0]` of `sfr_rdata_i`. A bit write drives the read byte with only that bit replaced, with `sfr_re_o` and `sfr_we_o` both high.
- R7: Kind 4 (push) increments the stack pointer and writes `wdata_i` to the byte it then addresses. FFh wraps to 00h with no indication. Other kinds, except pop, leave the pointer unchanged.
- R8: Kind 5 (pop) returns the byte at the stack pointer and then decrements it. 00h wraps to FFh.
- R9: A read (any kind with `we_i`=0 other than push, or a pop) puts its byte on `rdata_o`, its selected bit on `bit_o` and raises `rvalid_o` exactly one cycle after the request. Writes and pushes never raise `rvalid_o`.
- R10: `sfr_re_o` and `sfr_we_o` are high only in a request cycle that targets an SFR, and always with `sfr_addr_o` in 80h–FFh. `sfr_we_o` is high only for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request strobe |
| kind_i | input | 3 | Access kind: 0 reg, 1 direct, 2 indirect, 3 bit, 4 push, 5 pop |
| addr_i | input | 8 | Register number, direct address, pointer select or bit address |
| we_i | input | 1 | Write flag (ignored by push and pop) |
| wdata_i | input | 8 | Byte write data |
| bit_i | input | 1 | Bit value for bit writes |
| bank_i | input | 2 | Active register bank from the status register |
| rdata_o | output | 8 | Registered read byte |
| bit_o | output | 1 | Registered selected bit of the read byte |
| rvalid_o | output | 1 | Read result valid pulse |
| sp_o | output | 8 | Current stack pointer |
| sfr_re_o | output | 1 | SFR read strobe |
| sfr_we_o | output | 1 | SFR write strobe |
| sfr_bit_o | output | 1 | SFR access is a bit operation |
| sfr_addr_o | output | 8 | SFR address |
| sfr_wdata_o | output | 8 | SFR write byte |
| sfr_rdata_i | input | 8 | SFR read byte, combinational answer |

## Verification
Read bytes, selected bits and the valid pulse are due one rising edge after the request. RAM writes and the new stack pointer take effect at that same edge. SFR strobes, address and write byte are combinational and belong to the request cycle itself. The bench drives each request at a falling edge and samples registered results at the next falling edge, just after the capturing edge. It checks SFR strobes a nanosecond after driving, before the edge. A small SFR array in the bench answers reads combinationally and commits writes at the rising edge, so every value it returns can be predicted.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  typedef enum logic [2:0] {
    K_REG  = 3'd0,
    K_DIR  = 3'd1,
    K_IND  = 3'd2,
    K_BIT  = 3'd3,
    K_PUSH = 3'd4,
    K_POP  = 3'd5,
    K_RSV6 = 3'd6,
    K_RSV7 = 3'd7
  } acc_kind_e;
endpackage

// File: rtl/dmem_ram.sv
module dmem_ram #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_addr_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [AW-1:0] rb_addr_i,
  output logic [DW-1:0] rb_data_o,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mem[g] <= '0;
      else if (we_i && waddr_i == AW'(g))     mem[g] <= wdata_i;
    end
  end

  assign ra_data_o = mem[ra_addr_i];
  assign rb_data_o = mem[rb_addr_i];
endmodule

// File: rtl/dmem_sp.sv
module dmem_sp #(
  parameter int          AW       = 8,
  parameter logic [AW-1:0] SP_INIT = 8'h07
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] sp_inc_o
);
  logic [AW-1:0] sp_q;

  assign sp_inc_o = sp_q + AW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= SP_INIT;
    else if (push_i) sp_q <= sp_inc_o;
    else if (pop_i)  sp_q <= sp_q - AW'(1);
  end

  assign sp_o = sp_q;

  AST_SP_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> sp_o == $past(sp_o) + AW'(1)); // R7
  AST_SP_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> sp_o == $past(sp_o) - AW'(1)); // R8
  AST_SP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i) |=> $stable(sp_o)); // R7
endmodule

// File: rtl/dmem_decode.sv
module dmem_decode
  import dmem_pkg::*;
#(
  parameter int          AW       = 8,
  parameter int          BANK_W   = 2,
  parameter int          REG_W    = 3,
  parameter logic [AW-1:0] BIT_BASE = 8'h20
) (
  input  logic [2:0]        kind_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [AW-1:0]     ptr_val_i,
  input  logic [AW-1:0]     sp_i,
  input  logic [AW-1:0]     sp_inc_i,
  output logic [AW-1:0]     ptr_addr_o,
  output logic [AW-1:0]     tgt_addr_o,
  output logic              tgt_sfr_o,
  output logic              bit_mode_o,
  output logic [REG_W-1:0]  bit_idx_o,
  output logic              push_o,
  output logic              pop_o,
  output logic              known_o
);
  localparam int PAD_W = AW - BANK_W - REG_W;
  localparam int BYTE_SEL_W = AW - 1 - REG_W;

  acc_kind_e kind;
  assign kind = acc_kind_e'(kind_i);

  assign ptr_addr_o = {{PAD_W{1'b0}}, bank_i, {(REG_W-1){1'b0}}, addr_i[0]};
  assign bit_idx_o  = addr_i[REG_W-1:0];

  always_comb begin
    tgt_addr_o = addr_i;
    tgt_sfr_o  = 1'b0;
    bit_mode_o = 1'b0;
    push_o     = 1'b0;
    pop_o      = 1'b0;
    known_o    = 1'b1;
    unique case (kind)
      K_REG: tgt_addr_o = {{PAD_W{1'b0}}, bank_i, addr_i[REG_W-1:0]};
      K_DIR: tgt_sfr_o  = addr_i[AW-1];
      K_IND: tgt_addr_o = ptr_val_i;
      K_BIT: begin
        bit_mode_o = 1'b1;
        if (addr_i[AW-1]) begin
          tgt_sfr_o  = 1'b1;
          tgt_addr_o = {addr_i[AW-1:REG_W], {REG_W{1'b0}}};
        end else begin
          tgt_addr_o = BIT_BASE + AW'(addr_i[AW-2:REG_W]);
        end
      end
      K_PUSH: begin
        push_o     = 1'b1;
        tgt_addr_o = sp_inc_i;
      end
      K_POP: begin
        pop_o      = 1'b1;
        tgt_addr_o = sp_i;
      end
      default: known_o = 1'b0;
    endcase
  end

  logic [BYTE_SEL_W-1:0] unused_sel;
  assign unused_sel = '0;
endmodule

// File: rtl/dmem_front.sv
module dmem_front
  import dmem_pkg::*;
#(
  parameter int          DEPTH    = 256,
  parameter int          DW       = 8,
  parameter int          BANKS    = 4,
  parameter int          REGS     = 8,
  parameter logic [7:0]  SP_INIT  = 8'h07,
  parameter logic [7:0]  BIT_BASE = 8'h20,
  localparam int         AW       = $clog2(DEPTH),
  localparam int         BANK_W   = $clog2(BANKS),
  localparam int         REG_W    = $clog2(REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        kind_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              we_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              bit_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [DW-1:0]     rdata_o,
  output logic              bit_o,
  output logic              rvalid_o,
  output logic [AW-1:0]     sp_o,
  output logic              sfr_re_o,
  output logic              sfr_we_o,
  output logic              sfr_bit_o,
  output logic [AW-1:0]     sfr_addr_o,
  output logic [DW-1:0]     sfr_wdata_o,
  input  logic [DW-1:0]     sfr_rdata_i
);
  logic [AW-1:0]    ptr_addr, tgt_addr, sp_inc;
  logic [DW-1:0]    ptr_val, ram_rd;
  logic             tgt_sfr, bit_mode, push, pop, known;
  logic [REG_W-1:0] bit_idx;
  logic [DW-1:0]    rd_byte, wr_byte, bit_mask;
  logic             is_write, rd_en, ram_we, act_push, act_pop;

  dmem_decode #(
    .AW(AW), .BANK_W(BANK_W), .REG_W(REG_W), .BIT_BASE(BIT_BASE[AW-1:0])
  ) i_decode (
    .kind_i    (kind_i),
    .addr_i    (addr_i),
    .bank_i    (bank_i),
    .ptr_val_i (ptr_val),
    .sp_i      (sp_o),
    .sp_inc_i  (sp_inc),
    .ptr_addr_o(ptr_addr),
    .tgt_addr_o(tgt_addr),
    .tgt_sfr_o (tgt_sfr),
    .bit_mode_o(bit_mode),
    .bit_idx_o (bit_idx),
    .push_o    (push),
    .pop_o     (pop),
    .known_o   (known)
  );

  assign act_push = req_i && push;
  assign act_pop  = req_i && pop;

  dmem_sp #(.AW(AW), .SP_INIT(SP_INIT[AW-1:0])) i_sp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (act_push),
    .pop_i   (act_pop),
    .sp_o    (sp_o),
    .sp_inc_o(sp_inc)
  );

  dmem_ram #(.DEPTH(DEPTH), .DW(DW)) i_ram (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ra_addr_i(ptr_addr),
    .ra_data_o(ptr_val),
    .rb_addr_i(tgt_addr),
    .rb_data_o(ram_rd),
    .we_i     (ram_we),
    .waddr_i  (tgt_addr),
    .wdata_i  (wr_byte)
  );

  // byte seen by the access, from RAM or the SFR port
  assign rd_byte  = tgt_sfr ? sfr_rdata_i : ram_rd;
  assign bit_mask = DW'(1) << bit_idx;
  assign wr_byte  = bit_mode ? ((rd_byte & ~bit_mask) | ({DW{bit_i}} & bit_mask))
                             : wdata_i;

  assign is_write = push || (!pop && we_i);
  assign rd_en    = req_i && known && !is_write;
  assign ram_we   = req_i && known && is_write && !tgt_sfr;

  assign sfr_re_o    = req_i && tgt_sfr && (!is_write || bit_mode);
  assign sfr_we_o    = req_i && tgt_sfr && is_write;
  assign sfr_bit_o   = req_i && tgt_sfr && bit_mode;
  assign sfr_addr_o  = tgt_addr;
  assign sfr_wdata_o = wr_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      bit_o    <= 1'b0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en;
      if (rd_en) begin
        rdata_o <= rd_byte;
        bit_o   <= rd_byte[bit_idx];
      end
    end
  end

  AST_RVALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en |=> rvalid_o); // R9
  AST_RVALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |=> !rvalid_o); // R9
  AST_SFR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_re_o || sfr_we_o) |-> sfr_addr_o[AW-1]); // R10
  AST_SFR_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_re_o || sfr_we_o) |-> req_i); // R10
  AST_SFR_NO_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfr_we_o |-> !ram_we); // R3
  AST_BIT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we && bit_mode) |-> $countones(wr_byte ^ ram_rd) <= 1); // R5
  AST_SFR_BIT_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_we_o && sfr_bit_o) |-> $countones(sfr_wdata_o ^ sfr_rdata_i) <= 1); // R6
endmodule

// File: tb/test_dmem_front.sv
module test_dmem_front;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [2:0] kind = 3'd0;
  logic [7:0] addr = 8'h00;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       bitv = 1'b0;
  logic [1:0] bank = 2'd0;
  logic [7:0] rdata, sp, sfr_addr, sfr_wdata, sfr_rdata;
  logic       bit_out, rvalid, sfr_re, sfr_we, sfr_bit;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [7:0] sfr_m [128];

  always #2 clk = ~clk;

  dmem_front i_dmem_front (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .kind_i(kind), .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .bit_i(bitv), .bank_i(bank),
    .rdata_o(rdata), .bit_o(bit_out), .rvalid_o(rvalid), .sp_o(sp),
    .sfr_re_o(sfr_re), .sfr_we_o(sfr_we), .sfr_bit_o(sfr_bit),
    .sfr_addr_o(sfr_addr), .sfr_wdata_o(sfr_wdata), .sfr_rdata_i(sfr_rdata)
  );

  assign sfr_rdata = sfr_m[sfr_addr[6:0]];
  always @(posedge clk) if (sfr_we) sfr_m[sfr_addr[6:0]] <= sfr_wdata;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic op(input logic [2:0] k, input logic [7:0] a, input logic w,
                    input logic [7:0] d, input logic b);
    @(negedge clk);
    req = 1'b1; kind = k; addr = a; we = w; wdata = d; bitv = b;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [2:0] k, input logic [7:0] a, input logic [7:0] d);
    op(k, a, 1'b1, d, 1'b0);
  endtask

  task automatic rd(input logic [2:0] k, input logic [7:0] a);
    op(k, a, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 sp", sp, 8'h07);
    chk("R1 rvalid", rvalid, 0);
    rd(3'd1, 8'h33);
    chk("R1 ram clear", rdata, 8'h00);
  endtask

  task automatic t_banks;
    bank = 2'd2;
    wr(3'd0, 8'h05, 8'hA5);
    bank = 2'd0;
    rd(3'd1, 8'h15);
    chk("R2 bank2 r5 at 15h", rdata, 8'hA5);
    wr(3'd1, 8'h05, 8'h11);
    rd(3'd0, 8'h05);
    chk("R2 bank0 r5", rdata, 8'h11);
    bank = 2'd3;
    wr(3'd0, 8'h07, 8'h3E);
    rd(3'd1, 8'h1F);
    chk("R2 bank3 r7 at 1Fh", rdata, 8'h3E);
    bank = 2'd0;
  endtask

  task automatic t_direct;
    wr(3'd1, 8'h40, 8'h3C);
    rd(3'd1, 8'h40);
    chk("R3 direct low", rdata, 8'h3C);
    wr(3'd1, 8'h00, 8'h90);
    wr(3'd2, 8'h00, 8'h77);
    wr(3'd1, 8'h90, 8'h5A);
    chk("R3 sfr written", sfr_m[7'h10], 8'h5A);
    rd(3'd2, 8'h00);
    chk("R3 ram 90h untouched", rdata, 8'h77);
    rd(3'd1, 8'h90);
    chk("R3 direct sfr read", rdata, 8'h5A);
  endtask

  task automatic t_indirect;
    bank = 2'd1;
    wr(3'd1, 8'h09, 8'hC8);
    wr(3'd2, 8'h01, 8'h5E);
    rd(3'd2, 8'h01);
    chk("R4 via r1 upper", rdata, 8'h5E);
    rd(3'd1, 8'h48);
    chk("R4 direct 48h no alias", rdata, 8'h00);
    rd(3'd1, 8'hC8);
    chk("R4 sfr C8h untouched", rdata, 8'h00);
    wr(3'd1, 8'h08, 8'h40);
    rd(3'd2, 8'h00);
    chk("R4 via r0", rdata, 8'h3C);
    bank = 2'd0;
  endtask

  task automatic t_bit_ram;
    wr(3'd1, 8'h25, 8'h00);
    op(3'd3, 8'h2B, 1'b1, 8'h00, 1'b1);
    rd(3'd1, 8'h25);
    chk("R5 set bit3", rdata, 8'h08);
    op(3'd3, 8'h2F, 1'b1, 8'hFF, 1'b1);
    op(3'd3, 8'h2B, 1'b1, 8'hFF, 1'b0);
    rd(3'd1, 8'h25);
    chk("R5 set7 clr3", rdata, 8'h80);
    rd(3'd3, 8'h2F);
    chk("R5 bit read 1", bit_out, 1);
    rd(3'd3, 8'h2E);
    chk("R5 bit read 0", bit_out, 0);
    rd(3'd3, 8'h00);
    chk("R5 bit 0 of 20h", bit_out, 0);
  endtask

  task automatic t_bit_sfr;
    wr(3'd1, 8'h88, 8'hF0);
    @(negedge clk);
    req = 1'b1; kind = 3'd3; addr = 8'h8A; we = 1'b1; bitv = 1'b1;
    #1;
    chk("R6 sfr addr", sfr_addr, 8'h88);
    chk("R6 sfr bit flag", sfr_bit, 1);
    chk("R6 sfr re+we", {sfr_re, sfr_we}, 2'b11);
    chk("R6 sfr wdata", sfr_wdata, 8'hF4);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    rd(3'd1, 8'h88);
    chk("R6 sfr after bit write", rdata, 8'hF4);
    rd(3'd3, 8'h8C);
    chk("R6 sfr bit4", bit_out, 1);
    rd(3'd3, 8'h89);
    chk("R6 sfr bit1", bit_out, 0);
  endtask

  task automatic t_stack;
    op(3'd4, 8'h00, 1'b0, 8'h12, 1'b0);
    op(3'd4, 8'h00, 1'b0, 8'h34, 1'b0);
    chk("R7 sp after 2 push", sp, 8'h09);
    chk("R9 no rvalid on push", rvalid, 0);
    rd(3'd1, 8'h08);
    chk("R7 first push at 08h", rdata, 8'h12);
    rd(3'd5, 8'h00);
    chk("R8 pop value", rdata, 8'h34);
    chk("R8 sp after pop", sp, 8'h08);
    rd(3'd5, 8'h00);
    chk("R8 second pop", rdata, 8'h12);
    chk("R8 sp back", sp, 8'h07);
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 248; i++) op(3'd4, 8'h00, 1'b0, 8'(i), 1'b0);
    chk("R7 sp at FFh", sp, 8'hFF);
    op(3'd4, 8'h00, 1'b0, 8'hAB, 1'b0);
    chk("R7 sp wraps to 00h", sp, 8'h00);
    rd(3'd1, 8'h00);
    chk("R7 wrapped push at 00h", rdata, 8'hAB);
    rd(3'd5, 8'h00);
    chk("R8 pop at 00h", rdata, 8'hAB);
    chk("R8 sp wraps to FFh", sp, 8'hFF);
    rd(3'd5, 8'h00);
    chk("R8 pop at FFh", rdata, 8'hF7);
  endtask

  task automatic t_timing;
    @(negedge clk);
    req = 1'b1; kind = 3'd1; addr = 8'h40; we = 1'b0;
    #1;
    chk("R10 no sfr strobe for ram", {sfr_re, sfr_we}, 2'b00);
    @(negedge clk);
    req = 1'b0;
    chk("R9 rvalid after read", rvalid, 1);
    @(negedge clk);
    chk("R9 rvalid single pulse", rvalid, 0);
    @(negedge clk);
    req = 1'b1; kind = 3'd1; addr = 8'hA0; we = 1'b0;
    #1;
    chk("R10 sfr read strobe", {sfr_re, sfr_we}, 2'b10);
    @(negedge clk);
    req = 1'b0;
    #1;
    chk("R10 strobe gone", {sfr_re, sfr_we}, 2'b00);
    wr(3'd1, 8'h41, 8'h01);
    chk("R9 no rvalid after write", rvalid, 0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) sfr_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_banks();
    t_direct();
    t_indirect();
    t_bit_ram();
    t_bit_sfr();
    t_timing();
    t_stack();
    t_wrap();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule